// File: doc/BRIEF.md
# Flash Read Security Gate

This block decides whether the on-chip flash array is locked against debug access and filters read data accordingly. Each time the chip leaves reset, a load strobe copies the nonvolatile option byte into a working option register. One bit of that register is the security bit. It is active low: the erased value 1 means the flash is open, and 0 means it is locked. A new value in the nonvolatile byte has no effect until the next reset load.

Every read passes through a one-stage registered data path. Reads of RAM, direct-page registers and debug-controller registers always return the raw data. A flash read returns zeros in any of these cases: the debug port issues it while the part is secured, the debug-pin-enable bit is set, or the option register has not been loaded since reset. The block also records a completed mass erase. The load that follows then sees the erased option byte (all ones), and the part comes up unsecured. A mass erase followed by a reset is the only way to clear security.

Top module: `flash_sec_gate`

## Requirements
- R1: A load (`load_stb` high while `rst_hold` is low, with no mass erase recorded) copies `nv_opt` into the working option register. The new value appears on `opt_o` one cycle later.
- R2: `secure_o` is 1 when bit `SEC_BIT` (default bit 0) of the working option register is 0, and 0 when that bit is 1.
- R3: Changes on `nv_opt` leave `opt_o` and `secure_o` unchanged until the next load.
- R4: A flash read (`rd_space` = 0) with `rd_dbg` = 1 returns zero while secured. With `rd_dbg` = 0, or while unsecured, it returns the raw data.
- R5: A flash read returns zero whenever `dbg_pin_en` is 1, whatever the security state and the requester.
- R6: Reads with `rd_space` 1 (RAM), 2 (direct-page register) or 3 (debug-controller register) always return `rd_raw`, even while secured or with `dbg_pin_en` set.
- R7: A pulse on `erase_done` is recorded. The next load writes 8'hFF into the option register (unsecured) whatever `nv_opt` holds, and that load clears the record. Until that load, the option register keeps its value.
- R8: While `rst_hold` is high, the option register is held at all zeros (secured). From the start of `rst_hold` until the next load, every flash read returns zero.
- R9: `rd_valid` is high exactly one cycle after a cycle with `rd_en` high. `rd_data` is zero in any cycle where `rd_valid` is low.
- R10: A low `por_n` clears the option register and the recorded erase, leaving the part secured and unloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_hold | input | 1 | High while the chip is held in reset |
| load_stb | input | 1 | Option load strobe, issued after `rst_hold` falls |
| nv_opt | input | DW | Nonvolatile option byte as read from flash |
| erase_done | input | 1 | Pulse marking a completed mass erase |
| dbg_pin_en | input | 1 | Debug-pin-enable bit |
| rd_en | input | 1 | Read request |
| rd_dbg | input | 1 | Request comes from the background debug port |
| rd_space | input | 2 | Target: 0 flash, 1 RAM, 2 register, 3 debug-controller register |
| rd_raw | input | DW | Raw data from the addressed resource |
| rd_data | output | DW | Filtered read data |
| rd_valid | output | 1 | `rd_data` carries the answer to last cycle's request |
| secure_o | output | 1 | Flash is treated as secured |
| opt_o | output | DW | Working option register |

## Verification
A read answer appears one clock after `rd_en`, because it passes through one register stage. A load, a `rst_hold` assertion or a `por_n` assertion changes `opt_o` and `secure_o` on the clock edge where it is sampled. The bench drives every input on the falling edge and reads the outputs at the next falling edge, exactly one rising edge later. For R3 and R7, it waits several cycles before checking that the option register has not moved.

// File: rtl/flash_sec_gate.sv
module flash_sec_gate #(
  parameter int DW      = 8,
  parameter int SEC_BIT = 0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_hold,
  input  logic          load_stb,
  input  logic [DW-1:0] nv_opt,
  input  logic          erase_done,
  input  logic          dbg_pin_en,
  input  logic          rd_en,
  input  logic          rd_dbg,
  input  logic [1:0]    rd_space,
  input  logic [DW-1:0] rd_raw,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          secure_o,
  output logic [DW-1:0] opt_o
);

  localparam logic [1:0]    SPACE_FLASH = 2'd0;
  localparam logic [DW-1:0] ERASED      = '1;

  logic [DW-1:0] opt_q;
  logic          loaded_q;
  logic          erased_q;
  logic          do_load;
  logic          secured;
  logic          block;

  assign do_load = load_stb && !rst_hold;
  assign secured = !opt_q[SEC_BIT];
  assign block   = (rd_space == SPACE_FLASH) &&
                   (!loaded_q || dbg_pin_en || (rd_dbg && secured));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (rst_hold) begin
      opt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (do_load) begin
      opt_q    <= erased_q ? ERASED : nv_opt;
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          erased_q <= 1'b0;
    else if (erase_done) erased_q <= 1'b1;
    else if (do_load)    erased_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && !block) ? rd_raw : '0;
    end
  end

  assign secure_o = secured;
  assign opt_o    = opt_q;

endmodule

module flash_sec_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_hold,
  input logic          load_stb,
  input logic [DW-1:0] nv_opt,
  input logic          erased_q,
  input logic          dbg_pin_en,
  input logic          rd_en,
  input logic [1:0]    rd_space,
  input logic [DW-1:0] rd_raw,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          secure_o,
  input logic [DW-1:0] opt_o
);

  // R1
  load_copy_chk: assert property (@(posedge clk) disable iff (!por_n)
    load_stb && !rst_hold && !erased_q |=> opt_o == $past(nv_opt));

  // R7
  erase_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    load_stb && !rst_hold && erased_q |=> opt_o == '1 && !secure_o);

  // R3
  opt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !load_stb && !rst_hold |=> $stable(opt_o));

  // R8
  hold_secure_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_hold |=> secure_o && opt_o == '0);

  // R5
  pin_block_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_en && rd_space == 2'd0 && dbg_pin_en |=> rd_data == '0);

  // R6
  pass_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_en && rd_space != 2'd0 |=> rd_data == $past(rd_raw));

  // R9
  valid_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_en |=> rd_valid);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |=> !rd_valid && rd_data == '0);

endmodule

bind flash_sec_gate flash_sec_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_hold(rst_hold), .load_stb(load_stb),
  .nv_opt(nv_opt), .erased_q(erased_q), .dbg_pin_en(dbg_pin_en),
  .rd_en(rd_en), .rd_space(rd_space), .rd_raw(rd_raw), .rd_data(rd_data),
  .rd_valid(rd_valid), .secure_o(secure_o), .opt_o(opt_o)
);

// File: tb/test_flash_sec_gate.sv
module test_flash_sec_gate;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {space[1:0], dbg, pin, raw[7:0], exp[7:0]} checked with the part secured
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R4 CPU flash read passes
    {2'd0, 1'b1, 1'b0, 8'h5A, 8'h00},  // R4 debug flash read blocked
    {2'd1, 1'b1, 1'b0, 8'h77, 8'h77},  // R6 RAM
    {2'd2, 1'b1, 1'b0, 8'h81, 8'h81},  // R6 register
    {2'd3, 1'b1, 1'b0, 8'h19, 8'h19},  // R6 debug-controller register
    {2'd0, 1'b0, 1'b1, 8'hE4, 8'h00},  // R5 pin enable blocks CPU
    {2'd1, 1'b0, 1'b1, 8'h6D, 8'h6D},  // R6 RAM with pin enable
    {2'd0, 1'b1, 1'b1, 8'hFF, 8'h00}   // R5
  };

  logic clk = 0, por_n = 0, rst_hold = 1, load_stb = 0, erase_done = 0;
  logic dbg_pin_en = 0, rd_en = 0, rd_dbg = 0;
  logic [1:0] rd_space = 0;
  logic [7:0] nv_opt = 0, rd_raw = 0, rd_data, opt_o;
  logic rd_valid, secure_o;
  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_sec_gate i_flash_sec_gate (
    .clk(clk), .por_n(por_n), .rst_hold(rst_hold), .load_stb(load_stb),
    .nv_opt(nv_opt), .erase_done(erase_done), .dbg_pin_en(dbg_pin_en),
    .rd_en(rd_en), .rd_dbg(rd_dbg), .rd_space(rd_space), .rd_raw(rd_raw),
    .rd_data(rd_data), .rd_valid(rd_valid), .secure_o(secure_o), .opt_o(opt_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] sp, input logic dbg, input logic pin,
                         input logic [7:0] raw, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; rd_space = sp; rd_dbg = dbg; dbg_pin_en = pin; rd_raw = raw;
    @(negedge clk);
    rd_en = 0; dbg_pin_en = 0;
    check(tag, rd_data, exp);
    check({tag, " valid"}, {7'd0, rd_valid}, 8'd1);
  endtask

  task automatic reload(input logic [7:0] nv);
    @(negedge clk); rst_hold = 1; nv_opt = nv;
    @(negedge clk); rst_hold = 0; load_stb = 1;
    @(negedge clk); load_stb = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    check("R8 hold secure", {7'd0, secure_o}, 8'd1);
    check("R8 hold opt", opt_o, 8'h00);
    do_read(2'd0, 0, 0, 8'hC3, 8'h00, "R8 flash during hold");
    @(negedge clk); rst_hold = 0; nv_opt = 8'hA6;
    do_read(2'd0, 0, 0, 8'hC3, 8'h00, "R8 flash before load");
    @(negedge clk); load_stb = 1;
    @(negedge clk); load_stb = 0;
    check("R1 load", opt_o, 8'hA6);
    check("R2 secured", {7'd0, secure_o}, 8'd1);

    for (int i = 0; i < NV; i++)
      do_read(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], "table R4 R5 R6");

    @(negedge clk);
    check("R9 idle valid", {7'd0, rd_valid}, 8'd0);
    check("R9 idle data", rd_data, 8'd0);

    nv_opt = 8'h5B;
    repeat (4) @(negedge clk);
    check("R3 no effect", opt_o, 8'hA6);
    reload(8'h5B);
    check("R3 after reset", opt_o, 8'h5B);
    check("R2 unsecured", {7'd0, secure_o}, 8'd0);
    do_read(2'd0, 1, 0, 8'h99, 8'h99, "R4 debug read unsecured");
    do_read(2'd0, 1, 1, 8'h99, 8'h00, "R5 pin enable unsecured");

    reload(8'h00);
    check("R2 secured again", {7'd0, secure_o}, 8'd1);
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
    repeat (3) @(negedge clk);
    check("R7 before reset", opt_o, 8'h00);
    reload(8'h00);
    check("R7 erased load", opt_o, 8'hFF);
    check("R7 unsecured", {7'd0, secure_o}, 8'd0);
    reload(8'h00);
    check("R7 record cleared", opt_o, 8'h00);

    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0; por_n = 0;
    @(negedge clk);
    check("R10 por opt", opt_o, 8'h00);
    check("R10 por secure", {7'd0, secure_o}, 8'd1);
    por_n = 1;
    reload(8'h00);
    check("R10 erase record cleared", opt_o, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule